// File: doc/BRIEF.md
# Elastic Sample Buffer with Rate-Tracking Readout

This block takes audio words that arrive on an input strobe with irregular timing and replays them on a steady local timebase. Each accepted word goes into a circular store. A phase accumulator clocked from the clean local clock produces the read strobe. The output words are the input words in the same order, with no change to any bit. Only the moment each word appears is different.

The accumulator increment is the nominal value plus a proportional-integral correction. The correction is driven by the store occupancy minus its half-full target and is recomputed on every read. When the input runs fast, the store fills and the reads speed up. When the input runs slow, the reads slow down, so the occupancy stays near the middle.

Readout stays off until the store first reaches half full, which gives the loop a centred starting point. Two sticky flags record abnormal events. Overflow is set when a word arrives at a full store, and that word is discarded. Underflow is set when a read finds the store empty, and the previous word is presented again.

Top module: `elastic_rate_buf`

## Requirements
- R1: Every accepted input word appears on `out_data` exactly once, bit for bit unchanged, in arrival order, qualified by a one-cycle `out_strobe` pulse.
- R2: A word is accepted on any rising edge where `in_valid` is high and the store is not full; `fill` rises by one for each accepted word when no read happens on the same edge.
- R3: From reset until `locked` is high, `locked` is 0, `out_data` is 0 and `out_strobe` is never asserted.
- R4: `locked` goes high on the edge after `fill` first reaches DEPTH/2 and then stays high until reset.
- R5: Once locked, the accumulator adds the increment every cycle; a carry out of its top bit issues a read whose `out_strobe` pulse comes one cycle later. With the reset increment NOM_INC, the first pulse comes exactly 2^ACC_W/NOM_INC cycles after `locked` is first seen high.
- R6: On each read, the increment becomes NOM_INC + (e << KP_SH) + (I << KI_SH), clamped to [NOM_INC/2, 3*NOM_INC/2]. Here e = fill − DEPTH/2, and I is the running sum of e, clamped to ±INT_LIM. Under an input that is jittery and a few percent faster than nominal, this keeps `fill` strictly between 0 and DEPTH, and neither flag is set.
- R7: A word that arrives while `fill` equals DEPTH is discarded and leaves `fill` unchanged. It also sets `overflow`, which stays set until reset.
- R8: A read while `fill` is 0 leaves `out_data` at the previous word, still pulses `out_strobe`, and sets `underflow`, which stays set until reset.
- R9: `fill` always equals the number of words held, from 0 to DEPTH inclusive; reset clears it to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clean local reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word strobe (irregular timing) |
| in_data | input | DATA_W | Input sample word |
| out_strobe | output | 1 | One-cycle pulse marking a new output word |
| out_data | output | DATA_W | Output sample word |
| locked | output | 1 | Readout running (sticky after first half-full) |
| fill | output | AW+1 | Current occupancy of the store |
| overflow | output | 1 | Sticky: a word was dropped at full |
| underflow | output | 1 | Sticky: a read found the store empty |

## Verification
The main instance uses AW=5 (32 words) and NOM_INC=2^29. That gives one read every 8 cycles at nominal rate, so lock latency, several hundred transfers under a jittered input about 7% fast, and a full drain into underflow all fit in a short run. A second instance uses AW=3 and NOM_INC=0, which leaves the reader stalled after lock. That makes the full store and dropped writes reachable within a few cycles.

// File: rtl/erb_pkg.sv
package erb_pkg;
  typedef logic signed [63:0] wide_t;

  function automatic wide_t sat(input wide_t v, input wide_t lo, input wide_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction
endpackage

// File: rtl/erb_store.sv
module erb_store #(
  parameter int DATA_W = 24,
  parameter int AW     = 6,
  localparam int DEPTH = 1 << AW,
  localparam int CNT_W = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_req,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_strobe,
  output logic [CNT_W-1:0]  count,
  output logic              ovf,
  output logic              unf
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wptr, rptr;
  logic              is_full, is_empty;
  logic              wr_ok, wr_drop, rd_ok, rd_empty;

  assign is_full  = (count == CNT_W'(DEPTH));
  assign is_empty = (count == '0);
  assign wr_ok    = wr_req && !is_full;
  assign wr_drop  = wr_req && is_full;
  assign rd_ok    = rd_req && !is_empty;
  assign rd_empty = rd_req && is_empty;

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr      <= '0;
      rptr      <= '0;
      count     <= '0;
      rd_data   <= '0;
      rd_strobe <= 1'b0;
      ovf       <= 1'b0;
      unf       <= 1'b0;
    end else begin
      rd_strobe <= rd_req;
      if (wr_ok) wptr <= wptr + 1'b1;
      if (rd_ok) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem[rptr];
      end
      count <= count + CNT_W'(wr_ok) - CNT_W'(rd_ok);
      if (wr_drop)  ovf <= 1'b1;
      if (rd_empty) unf <= 1'b1;
    end
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH)); // R9
  AST_DROP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> count <= $past(count)); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf); // R7
  AST_UNF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    unf |=> unf); // R8
  AST_EMPTY_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_empty |=> (rd_data == $past(rd_data)) && unf); // R8
endmodule

// File: rtl/erb_nco.sv
module erb_nco #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [ACC_W-1:0] inc,
  output logic             carry
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W:0]   sum;

  assign sum   = {1'b0, acc} + {1'b0, inc};
  assign carry = en && sum[ACC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)  acc <= '0;
    else if (en) acc <= sum[ACC_W-1:0];
  end

  AST_NCO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc)); // R5
endmodule

// File: rtl/erb_rate_pi.sv
module erb_rate_pi
  import erb_pkg::*;
#(
  parameter int      ACC_W   = 32,
  parameter int      CNT_W   = 7,
  parameter int      HALF    = 32,
  parameter longint  NOM_INC = 64'd536870912,
  parameter int      KP_SH   = 24,
  parameter int      KI_SH   = 18,
  parameter longint  INT_LIM = 64'd4096
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             update,
  input  logic [CNT_W-1:0] fill,
  output logic [ACC_W-1:0] inc
);
  localparam wide_t INC_MIN = wide_t'(NOM_INC / 2);
  localparam wide_t INC_MAX = wide_t'(NOM_INC + NOM_INC / 2);

  wide_t err, integ, integ_nx;

  function automatic logic [ACC_W-1:0] next_inc(input wide_t e, input wide_t i);
    wide_t raw;
    raw = wide_t'(NOM_INC) + (e <<< KP_SH) + (i <<< KI_SH);
    return ACC_W'(sat(raw, INC_MIN, INC_MAX));
  endfunction

  assign err      = wide_t'({1'b0, fill}) - wide_t'(HALF);
  assign integ_nx = sat(integ + err, -wide_t'(INT_LIM), wide_t'(INT_LIM));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      integ <= '0;
      inc   <= ACC_W'(NOM_INC);
    end else if (update) begin
      integ <= integ_nx;
      inc   <= next_inc(err, integ_nx);
    end
  end

  AST_INC_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (wide_t'({1'b0, inc}) >= INC_MIN) && (wide_t'({1'b0, inc}) <= INC_MAX)); // R6
  AST_INC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !update |=> $stable(inc)); // R6
endmodule

// File: rtl/elastic_rate_buf.sv
module elastic_rate_buf #(
  parameter int     DATA_W  = 24,
  parameter int     AW      = 6,
  parameter int     ACC_W   = 32,
  parameter longint NOM_INC = 64'd536870912,
  parameter int     KP_SH   = 24,
  parameter int     KI_SH   = 18,
  parameter longint INT_LIM = 64'd4096,
  localparam int    DEPTH   = 1 << AW,
  localparam int    HALF    = DEPTH / 2,
  localparam int    CNT_W   = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_strobe,
  output logic [DATA_W-1:0] out_data,
  output logic              locked,
  output logic [CNT_W-1:0]  fill,
  output logic              overflow,
  output logic              underflow
);
  logic             nco_carry;
  logic [ACC_W-1:0] nco_inc;
  logic             half_reached;

  assign half_reached = (fill >= CNT_W'(HALF));

  always_ff @(posedge clk) begin
    if (!rst_n) locked <= 1'b0;
    else if (half_reached) locked <= 1'b1;
  end

  erb_store #(.DATA_W(DATA_W), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_req(in_valid), .wr_data(in_data),
    .rd_req(nco_carry),
    .rd_data(out_data), .rd_strobe(out_strobe),
    .count(fill), .ovf(overflow), .unf(underflow)
  );

  erb_nco #(.ACC_W(ACC_W)) u_nco (
    .clk(clk), .rst_n(rst_n), .en(locked), .inc(nco_inc), .carry(nco_carry)
  );

  erb_rate_pi #(
    .ACC_W(ACC_W), .CNT_W(CNT_W), .HALF(HALF), .NOM_INC(NOM_INC),
    .KP_SH(KP_SH), .KI_SH(KI_SH), .INT_LIM(INT_LIM)
  ) u_pi (
    .clk(clk), .rst_n(rst_n), .update(nco_carry), .fill(fill), .inc(nco_inc)
  );

  AST_NO_READ_BEFORE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> !out_strobe && (out_data == '0)); // R3
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked); // R4
  AST_LOCK_ON_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && half_reached) |=> locked); // R4
  AST_READ_ON_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    nco_carry |=> out_strobe); // R5
endmodule

// File: tb/elastic_rate_buf_bench.sv
module elastic_rate_buf_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 24;
  localparam int AW     = 5;
  localparam int DEPTH  = 1 << AW;
  localparam int HALF   = DEPTH / 2;
  localparam longint NOM = 64'd536870912;
  localparam int RD_GAP = int'((64'd1 << 32) / NOM);
  localparam int AW2    = 3;
  localparam int DEPTH2 = 1 << AW2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic              in_valid = 1'b0;
  logic [DATA_W-1:0] in_data = '0;
  logic              out_strobe, locked, overflow, underflow;
  logic [DATA_W-1:0] out_data;
  logic [AW:0]       fill;

  logic              v2 = 1'b0;
  logic [DATA_W-1:0] d2 = '0;
  logic              s2, l2, o2, u2;
  logic [DATA_W-1:0] q2;
  logic [AW2:0]      f2;

  elastic_rate_buf #(.DATA_W(DATA_W), .AW(AW), .NOM_INC(NOM)) u_elastic_rate_buf (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .out_strobe(out_strobe), .out_data(out_data), .locked(locked),
    .fill(fill), .overflow(overflow), .underflow(underflow)
  );

  elastic_rate_buf #(.DATA_W(DATA_W), .AW(AW2), .NOM_INC(64'd0)) u_ovf (
    .clk(clk), .rst_n(rst_n), .in_valid(v2), .in_data(d2),
    .out_strobe(s2), .out_data(q2), .locked(l2),
    .fill(f2), .overflow(o2), .underflow(u2)
  );

  int errors = 0;
  int checks = 0;
  logic [DATA_W-1:0] sb[$];
  logic [DATA_W-1:0] last_word = '0;
  bit  tracking = 0, draining = 0, seen_lock = 0, first_done = 0;
  int  lock_cnt = 0, repeats = 0, outputs = 0;
  int  min_fill = 1000, max_fill = -1;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [DATA_W-1:0] pattern(input int i);
    return DATA_W'((i * 32'h009E3779) ^ (i << 7) ^ 32'h00A5C3);
  endfunction

  task automatic send(input logic [DATA_W-1:0] v, input int gap);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = v;
    sb.push_back(v);
    last_word = v;
    for (int g = 1; g < gap; g++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: scoreboard pops on each output pulse
  always @(negedge clk) begin
    if (rst_n) begin
      if (!locked && out_strobe)
        check(1'b0, "R3 strobe before lock", 1, 0);
      if (locked && !seen_lock) begin
        seen_lock = 1;
        lock_cnt  = 0;
      end else if (seen_lock && !first_done) begin
        lock_cnt++;
        if (out_strobe) begin
          first_done = 1;
          check(lock_cnt == RD_GAP, "R5 first read latency", lock_cnt, RD_GAP);
        end
      end
      if (out_strobe) begin
        if (sb.size() > 0) begin
          logic [DATA_W-1:0] e;
          e = sb.pop_front();
          outputs++;
          check(out_data == e, "R1 word order/value", out_data, e);
        end else begin
          repeats++;
          check(out_data == last_word, "R8 repeat on empty", out_data, last_word);
          check(underflow == 1'b1, "R8 underflow flag", underflow, 1);
        end
      end
      if (tracking) begin
        if (int'(fill) < min_fill) min_fill = int'(fill);
        if (int'(fill) > max_fill) max_fill = int'(fill);
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int gaps[6];
    gaps = '{5, 9, 7, 10, 6, 8};
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // reset state
    check(fill == 0, "R9 fill after reset", fill, 0);
    check(locked == 0, "R3 locked after reset", locked, 0);
    check(out_data == 0, "R3 out_data after reset", out_data, 0);
    check(overflow == 0 && underflow == 0, "R7 flags after reset", overflow, 0);

    // fill up to one short of half, back to back
    for (int i = 0; i < HALF - 1; i++) send(pattern(i), 1);
    @(negedge clk); in_valid = 1'b0;
    check(fill == HALF - 1, "R2 fill counts writes", fill, HALF - 1);
    check(locked == 0, "R3 still unlocked below half", locked, 0);
    check(out_data == 0, "R3 output zero before lock", out_data, 0);
    send(pattern(HALF - 1), 1);
    @(negedge clk); in_valid = 1'b0;
    check(fill == HALF, "R9 fill at half", fill, HALF);
    @(negedge clk);
    check(locked == 1, "R4 lock after half", locked, 1);

    // tracking phase: jittered input ~7% fast
    tracking = 1;
    for (int i = HALF; i < HALF + 360; i++) send(pattern(i), gaps[i % 6]);
    tracking = 0;
    check(min_fill > 0, "R6 fill stays above empty", min_fill, 1);
    check(max_fill < DEPTH, "R6 fill stays below full", max_fill, DEPTH - 1);
    check(overflow == 0, "R6 no overflow while tracking", overflow, 0);
    check(underflow == 0, "R6 no underflow while tracking", underflow, 0);
    check(locked == 1, "R4 lock sticky", locked, 1);

    // drain into underflow
    @(negedge clk); in_valid = 1'b0;
    repeat (1200) @(negedge clk);
    check(sb.size() == 0, "R1 all words delivered", sb.size(), 0);
    check(outputs == HALF + 360, "R1 output count", outputs, HALF + 360);
    check(fill == 0, "R9 fill empty after drain", fill, 0);
    check(repeats > 0, "R8 empty reads seen", repeats, 1);
    check(underflow == 1, "R8 underflow sticky", underflow, 1);
    check(out_data == last_word, "R8 last word held", out_data, last_word);

    // overflow instance: reader stalled, fill to full then push more
    for (int i = 0; i < DEPTH2; i++) begin
      @(negedge clk); v2 = 1'b1; d2 = pattern(1000 + i);
    end
    @(negedge clk); v2 = 1'b0;
    check(f2 == DEPTH2, "R2 small store full", f2, DEPTH2);
    check(o2 == 0, "R7 no overflow at exactly full", o2, 0);
    @(negedge clk); v2 = 1'b1; d2 = 24'h123456;
    @(negedge clk); d2 = 24'h654321;
    @(negedge clk); v2 = 1'b0;
    check(f2 == DEPTH2, "R7 dropped writes leave fill", f2, DEPTH2);
    check(o2 == 1, "R7 overflow set", o2, 1);
    repeat (3) @(negedge clk);
    check(o2 == 1, "R7 overflow sticky", o2, 1);
    check(s2 == 0 && q2 == 0, "R7 no output from stalled reader", q2, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule